// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This unit takes an IEEE-754 single-precision operand and turns it into a 32-bit or 16-bit fixed-point integer, either signed or unsigned. A small fraction-bit count tells the unit how many binary places the integer keeps. The operand is multiplied by two to the power of that count, and the fractional part that is left is cut off, so rounding is always toward zero. Values outside the target range saturate to the nearest limit.

A flush control lets subnormal operands be treated as zero, with a flag that records it. Each converted value comes with three status pulses: invalid, inexact and input-denormal. An accepted operand is registered and appears on the outputs one clock later, together with its valid strobe.

Top module: `f2fix_conv`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `result` and all three flags are cleared on that edge, even if `in_valid` is high.
- R2: `out_valid` equals the `in_valid` of the previous cycle. The flags are only high in a cycle where `out_valid` is high. `result` keeps its value through cycles with no accepted operand.
- R3: A finite operand x gives trunc(x * 2^frac_bits), the integer part with the fraction dropped toward zero. When nothing is dropped and the value is in range, no flag is raised.
- R4: When in-range truncation drops a nonzero fraction, `flag_inexact` is high and `flag_invalid` is low.
- R5: A NaN operand (exponent field bits 30:23 all ones, bits 22:0 nonzero) gives a result of 0 with `flag_invalid` high and `flag_inexact` low.
- R6: With `flush_en` high, a subnormal operand (bits 30:23 zero, bits 22:0 nonzero) gives 0 with `flag_denorm_in` high and the other two flags low. With `flush_en` low, a subnormal is converted by its true value, and `flag_denorm_in` stays low.
- R7: In signed full-width mode, a truncated value below -2^31 gives 0x80000000 and one above 2^31-1 gives 0x7FFFFFFF. Infinities are out of range in the direction of their sign. Each clamp raises `flag_invalid` and leaves `flag_inexact` low.
- R8: In unsigned mode, a negative truncated value gives 0, and a value above the maximum (2^32-1, or 65535 in half mode) gives all ones of the active width. Both raise `flag_invalid`. A negative operand that truncates to zero, such as -0.5, gives 0 with only `flag_inexact` raised.
- R9: With `half_mode` high, the range is -32768..32767 when signed and 0..65535 when unsigned, and the same clamp and flag rules apply. A signed 16-bit result is sign-extended into the 32-bit output. An unsigned one is zero-extended.
- R10: `flag_invalid` and `flag_inexact` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| op_bits | input | 32 | Single-precision operand |
| signed_mode | input | 1 | 1 = signed result, 0 = unsigned |
| half_mode | input | 1 | 1 = 16-bit range, 0 = 32-bit range |
| frac_bits | input | FRAC_W | Number of fraction bits in the result |
| flush_en | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | OUT_W | Fixed-point result |
| flag_invalid | output | 1 | NaN or saturation pulse |
| flag_inexact | output | 1 | Nonzero fraction discarded pulse |
| flag_denorm_in | output | 1 | Subnormal operand flushed pulse |

## Verification
The hardest cases to reach are the exact range edges. Examples are -2^31 in signed mode, which must not clamp, 65535.0 against 65536.0 in unsigned half mode, and a small negative value in unsigned mode that truncates to zero rather than clamping. Random operands almost never land on these edges. Directed operands place them there with chosen fraction counts. The random stimulus draws exponents near the saturation threshold and also draws subnormal and all-ones exponent fields, so the clamp, the NaN path and both flush settings all get exercised.

// File: rtl/f2fix_pkg.sv
package f2fix_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int FLT_W = EXP_W + MAN_W + 1;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_e;

  typedef struct packed {
    logic             sign;
    fcls_e            cls;
    logic [EXP_W-1:0] exp_eff;
    logic [MAN_W:0]   sig;
  } fop_t;
endpackage

// File: rtl/f2fix_unpack.sv
module f2fix_unpack
  import f2fix_pkg::*;
(
  input  logic [FLT_W-1:0] op_i,
  input  logic             flush_i,
  output fop_t             fop_o,
  output logic             denorm_o
);
  logic [EXP_W-1:0] e_fld;
  logic [MAN_W-1:0] f_fld;
  logic             e_ones, e_zero, f_zero;

  always_comb begin
    e_fld  = op_i[MAN_W +: EXP_W];
    f_fld  = op_i[MAN_W-1:0];
    e_ones = &e_fld;
    e_zero = ~|e_fld;
    f_zero = ~|f_fld;
    // flushed subnormal operand
    denorm_o = flush_i & e_zero & ~f_zero;
    fop_o.sign    = op_i[FLT_W-1];
    // subnormals share the scale of the smallest normal exponent
    fop_o.exp_eff = e_zero ? EXP_W'(1) : e_fld;
    fop_o.sig     = {~e_zero, f_fld};
    if (e_ones)
      fop_o.cls = f_zero ? CLS_INF : CLS_NAN;
    else if ((e_zero & f_zero) | denorm_o)
      fop_o.cls = CLS_ZERO;
    else
      fop_o.cls = CLS_FIN;
  end
endmodule

// File: rtl/f2fix_scale.sv
module f2fix_scale
  import f2fix_pkg::*;
#(
  parameter int FRAC_W = 5,
  parameter int OUT_W  = 32,
  parameter int LSH_LIM = OUT_W - MAN_W,
  parameter int MAG_W   = MAN_W + 1 + LSH_LIM
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MAN_W:0]    sig_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [MAG_W-1:0]  mag_o,
  output logic              huge_o,
  output logic              lost_o
);
  localparam logic [MAN_W:0] ONES = {(MAN_W+1){1'b1}};

  int shamt;

  always_comb begin
    // net binary exponent of the scaled integer significand
    shamt  = int'(exp_i) - BIAS - MAN_W + int'(frac_i);
    mag_o  = '0;
    huge_o = 1'b0;
    lost_o = 1'b0;
    if (shamt > LSH_LIM) begin
      huge_o = 1'b1;
    end else if (shamt >= 0) begin
      mag_o = MAG_W'(sig_i) << shamt;
    end else if (-shamt > MAN_W) begin
      lost_o = |sig_i;
    end else begin
      mag_o  = MAG_W'(sig_i >> (-shamt));
      lost_o = |(sig_i & ~(ONES << (-shamt)));
    end
  end
endmodule

// File: rtl/f2fix_clamp.sv
module f2fix_clamp
  import f2fix_pkg::*;
#(
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16,
  parameter int MAG_W  = 33
) (
  input  fcls_e             cls_i,
  input  logic              sign_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              huge_i,
  input  logic              lost_i,
  input  logic              signed_i,
  input  logic              half_i,
  output logic [OUT_W-1:0]  res_o,
  output logic              inv_o,
  output logic              inx_o
);
  // largest magnitudes allowed before a clamp
  localparam logic [MAG_W-1:0] F_SMAX = MAG_W'((64'd1 << (OUT_W-1)) - 64'd1);
  localparam logic [MAG_W-1:0] F_SNEG = MAG_W'(64'd1 << (OUT_W-1));
  localparam logic [MAG_W-1:0] F_UMAX = MAG_W'((64'd1 << OUT_W) - 64'd1);
  localparam logic [MAG_W-1:0] H_SMAX = MAG_W'((64'd1 << (HALF_W-1)) - 64'd1);
  localparam logic [MAG_W-1:0] H_SNEG = MAG_W'(64'd1 << (HALF_W-1));
  localparam logic [MAG_W-1:0] H_UMAX = MAG_W'((64'd1 << HALF_W) - 64'd1);
  // saturated output codes
  localparam logic [OUT_W-1:0] F_SLO = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] F_SHI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] H_SLO = {{(OUT_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] H_SHI = {{(OUT_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] F_UHI = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] H_UHI = {{(OUT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [MAG_W-1:0] lim_pos, lim_neg, mval;
  logic [OUT_W-1:0] sat_hi, sat_lo;
  logic             over;

  always_comb begin
    lim_pos = half_i ? (signed_i ? H_SMAX : H_UMAX) : (signed_i ? F_SMAX : F_UMAX);
    lim_neg = signed_i ? (half_i ? H_SNEG : F_SNEG) : '0;
    sat_hi  = half_i ? (signed_i ? H_SHI : H_UHI) : (signed_i ? F_SHI : F_UHI);
    sat_lo  = signed_i ? (half_i ? H_SLO : F_SLO) : '0;
    over    = 1'b0;
    mval    = '0;
    res_o   = '0;
    inv_o   = 1'b0;
    inx_o   = 1'b0;
    unique case (cls_i)
      CLS_NAN:  inv_o = 1'b1;
      CLS_ZERO: res_o = '0;
      default: begin
        over = (cls_i == CLS_INF) | huge_i |
               (sign_i ? (mag_i > lim_neg) : (mag_i > lim_pos));
        if (over) begin
          inv_o = 1'b1;
          res_o = sign_i ? sat_lo : sat_hi;
        end else begin
          inx_o = lost_i;
          mval  = sign_i ? (~mag_i + MAG_W'(1)) : mag_i;
          res_o = mval[OUT_W-1:0];
        end
      end
    endcase
  end
endmodule

// File: rtl/f2fix_conv.sv
module f2fix_conv
  import f2fix_pkg::*;
#(
  parameter int FRAC_W = 5,
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       op_bits,
  input  logic              signed_mode,
  input  logic              half_mode,
  input  logic [FRAC_W-1:0] frac_bits,
  input  logic              flush_en,
  output logic              out_valid,
  output logic [OUT_W-1:0]  result,
  output logic              flag_invalid,
  output logic              flag_inexact,
  output logic              flag_denorm_in
);
  localparam int LSH_LIM = OUT_W - MAN_W;
  localparam int MAG_W   = MAN_W + 1 + LSH_LIM;

  fop_t             fop;
  logic             dn_c, huge_c, lost_c, inv_c, inx_c;
  logic [MAG_W-1:0] mag_c;
  logic [OUT_W-1:0] res_c;

  f2fix_unpack u_unpack (
    .op_i    (op_bits),
    .flush_i (flush_en),
    .fop_o   (fop),
    .denorm_o(dn_c)
  );

  f2fix_scale #(
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W),
    .LSH_LIM(LSH_LIM),
    .MAG_W  (MAG_W)
  ) u_scale (
    .exp_i (fop.exp_eff),
    .sig_i (fop.sig),
    .frac_i(frac_bits),
    .mag_o (mag_c),
    .huge_o(huge_c),
    .lost_o(lost_c)
  );

  f2fix_clamp #(
    .OUT_W (OUT_W),
    .HALF_W(HALF_W),
    .MAG_W (MAG_W)
  ) u_clamp (
    .cls_i   (fop.cls),
    .sign_i  (fop.sign),
    .mag_i   (mag_c),
    .huge_i  (huge_c),
    .lost_i  (lost_c),
    .signed_i(signed_mode),
    .half_i  (half_mode),
    .res_o   (res_c),
    .inv_o   (inv_c),
    .inx_o   (inx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_invalid   <= 1'b0;
      flag_inexact   <= 1'b0;
      flag_denorm_in <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      flag_invalid   <= in_valid & inv_c;
      flag_inexact   <= in_valid & inx_c;
      flag_denorm_in <= in_valid & dn_c;
      if (in_valid) result <= res_c;
    end
  end
endmodule

// File: rtl/f2fix_chk.sv
module f2fix_chk #(
  parameter int OUT_W  = 32,
  parameter int HALF_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      op_bits,
  input logic             signed_mode,
  input logic             half_mode,
  input logic             flush_en,
  input logic             out_valid,
  input logic [OUT_W-1:0] result,
  input logic             flag_invalid,
  input logic             flag_inexact,
  input logic             flag_denorm_in
);
  logic op_nan, op_sub, op_pinf;
  assign op_nan  = (&op_bits[30:23]) & (|op_bits[22:0]);
  assign op_sub  = ~(|op_bits[30:23]) & (|op_bits[22:0]);
  assign op_pinf = ~op_bits[31] & (&op_bits[30:23]) & ~(|op_bits[22:0]);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !flag_invalid && !flag_inexact && !flag_denorm_in));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  a_r2_flags_with_valid: assert property (@(posedge clk) disable iff (rst)
    (flag_invalid || flag_inexact || flag_denorm_in) |-> out_valid);

  a_r2_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(result));

  a_r5_nan_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_nan) |=> (result == '0 && flag_invalid && !flag_inexact));

  a_r6_flush_sub: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flush_en && op_sub) |=>
      (result == '0 && flag_denorm_in && !flag_invalid && !flag_inexact));

  a_r6_no_flush_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush_en) |=> !flag_denorm_in);

  a_r7_pinf_clamp: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_pinf && signed_mode && !half_mode) |=>
      (result == {1'b0, {(OUT_W-1){1'b1}}} && flag_invalid));

  a_r9_uhalf_zext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_mode && !signed_mode) |=> (result[OUT_W-1:HALF_W] == '0));

  a_r10_flag_excl: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |-> !flag_inexact);
endmodule

bind f2fix_conv f2fix_chk #(.OUT_W(OUT_W), .HALF_W(HALF_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .op_bits       (op_bits),
  .signed_mode   (signed_mode),
  .half_mode     (half_mode),
  .flush_en      (flush_en),
  .out_valid     (out_valid),
  .result        (result),
  .flag_invalid  (flag_invalid),
  .flag_inexact  (flag_inexact),
  .flag_denorm_in(flag_denorm_in)
);

// File: tb/sim_f2fix_conv.sv
`timescale 1ns/1ps
module sim_f2fix_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_bits = '0;
  logic        signed_mode = 1'b0;
  logic        half_mode = 1'b0;
  logic [4:0]  frac_bits = '0;
  logic        flush_en = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_inexact, flag_denorm_in;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;
  logic [31:0] last_res = '0;

  always #4 clk = ~clk;

  f2fix_conv u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_bits(op_bits),
    .signed_mode(signed_mode), .half_mode(half_mode), .frac_bits(frac_bits),
    .flush_en(flush_en), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .flag_denorm_in(flag_denorm_in)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected conversion from the requirements, using real arithmetic
  function automatic void ref_conv(input logic [31:0] op, input logic sgn, input logic hlf,
                                   input logic fz, input int fb, output logic [31:0] r,
                                   output logic inv, output logic inx, output logic dn);
    int  e;
    real v, t, p;
    longint lo, hi;
    bit  is_inf;
    e = int'(op[30:23]);
    r = '0; inv = 1'b0; inx = 1'b0; dn = 1'b0; is_inf = 1'b0; v = 0.0; t = 0.0;
    lo = sgn ? (hlf ? -64'sd32768 : -64'sd2147483648) : 64'sd0;
    hi = sgn ? (hlf ? 64'sd32767 : 64'sd2147483647) : (hlf ? 64'sd65535 : 64'sd4294967295);
    if (e == 255 && op[22:0] != 0) begin
      inv = 1'b1;
      return;
    end
    if (e == 0 && op[22:0] != 0 && fz) begin
      dn = 1'b1;
      return;
    end
    if (e == 255) is_inf = 1'b1;
    else begin
      p = 1.0;
      for (int k = 0; k < ((e == 0 ? 1 : e) - 150 + fb); k++) p = p * 2.0;
      for (int k = 0; k < -((e == 0 ? 1 : e) - 150 + fb); k++) p = p / 2.0;
      v = real'(int'(op[22:0]) + (e == 0 ? 0 : 8388608)) * p;
      if (op[31]) v = -v;
      t = (v >= 0.0) ? $floor(v) : $ceil(v);
    end
    if (is_inf) begin
      inv = 1'b1;
      r = op[31] ? 32'(lo) : 32'(hi);
    end else if (t > real'(hi)) begin
      inv = 1'b1;
      r = 32'(hi);
    end else if (t < real'(lo)) begin
      inv = 1'b1;
      r = 32'(lo);
    end else begin
      r = 32'(longint'(t));
      inx = (t != v);
    end
  endfunction

  task automatic run(input logic [31:0] op, input logic sgn, input logic hlf,
                     input logic fz, input int fb, input string tag);
    logic [31:0] er;
    logic ei, ex, ed;
    ref_conv(op, sgn, hlf, fz, fb, er, ei, ex, ed);
    @(negedge clk);
    op_bits = op; signed_mode = sgn; half_mode = hlf; flush_en = fz;
    frac_bits = 5'(fb); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, flag_invalid, flag_inexact, flag_denorm_in, result},
               {1'b1, ei, ex, ed, er});
    last_res = er;
    @(negedge clk);
    // R2: idle cycle holds result and drops strobe and flags
    check("R2 idle", {out_valid, flag_invalid, flag_inexact, flag_denorm_in, result},
                     {4'b0000, last_res});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset", {out_valid, flag_invalid, flag_inexact, flag_denorm_in, result}, '0);
    rst = 1'b0;

    run(32'h3F800000, 1'b1, 1'b0, 1'b0, 0,  "R3 one");
    run(32'h3FC00000, 1'b0, 1'b0, 1'b0, 1,  "R3 1.5 fb1");
    run(32'hC0300000, 1'b1, 1'b0, 1'b0, 2,  "R3 -2.75 fb2");
    run(32'h4F32D05E, 1'b0, 1'b0, 1'b0, 0,  "R3 3e9 unsigned");
    run(32'h3FA00000, 1'b1, 1'b0, 1'b0, 0,  "R4 1.25");
    run(32'h7FC00000, 1'b1, 1'b0, 1'b0, 3,  "R5 nan");
    run(32'hFF800001, 1'b0, 1'b1, 1'b1, 0,  "R5 nan unsigned half");
    run(32'h00400000, 1'b1, 1'b0, 1'b1, 31, "R6 flush on");
    run(32'h80000001, 1'b0, 1'b0, 1'b1, 0,  "R6 flush neg");
    run(32'h00400000, 1'b1, 1'b0, 1'b0, 31, "R6 flush off");
    run(32'h4F000000, 1'b1, 1'b0, 1'b0, 0,  "R7 2^31 clamp");
    run(32'hCF000000, 1'b1, 1'b0, 1'b0, 0,  "R7 -2^31 exact");
    run(32'h7F800000, 1'b1, 1'b0, 1'b0, 0,  "R7 +inf");
    run(32'hFF800000, 1'b1, 1'b0, 1'b0, 0,  "R7 -inf");
    run(32'hBF000000, 1'b0, 1'b0, 1'b0, 0,  "R8 -0.5 unsigned");
    run(32'hBF800000, 1'b0, 1'b0, 1'b0, 0,  "R8 -1 unsigned");
    run(32'h42200000, 1'b0, 1'b0, 1'b0, 27, "R8 over unsigned");
    run(32'h7F800000, 1'b0, 1'b1, 1'b0, 0,  "R8 +inf unsigned half");
    run(32'hBF800000, 1'b1, 1'b1, 1'b0, 0,  "R9 -1 signed half");
    run(32'h477FFF00, 1'b0, 1'b1, 1'b0, 0,  "R9 65535 half");
    run(32'h47800000, 1'b0, 1'b1, 1'b0, 0,  "R9 65536 half");
    run(32'hC71C4000, 1'b1, 1'b1, 1'b0, 0,  "R9 -40000 half");
    run(32'h46FFFE00, 1'b1, 1'b1, 1'b0, 0,  "R9 32767 half");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op;
      op = $urandom;
      case ($urandom % 5)
        0, 1: op[30:23] = 8'(118 + $urandom % 48);
        2:    op[30:23] = 8'd0;
        3:    op[30:23] = 8'd255;
        default: ;
      endcase
      run(op, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 32), "R3/R4/R10 random");
    end

    // R1: reset wins over an accepted operand
    @(negedge clk);
    op_bits = 32'h7FC00000; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset over valid", {out_valid, flag_invalid, flag_inexact, flag_denorm_in, result}, '0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule